// File: doc/BRIEF.md
# Pin-Clocked Bit Counter Timer

This timer counts the bits of each serial word. It counts transitions of the bus clock line, not cycles of the system clock. It works beside a baud timer that drives the clock line. The inverted clock-pin input first passes through a synchronizer. Each transition that reaches the far side of the synchronizer is one count event. Because the block counts real bus transitions, a clock that a slave holds low (a stretched clock) slows the bit count to match.

The block follows the enable state of the master baud timer. When that enable rises, the block frames a start-bit period. It then runs a data period of `cmp + 1` pin transitions (two per bit), so an 8-bit word uses a compare value of 15. When the data period ends it gives a one-cycle word-done pulse and frames a stop-bit period. After that it begins the start period of the next word. A shift-clock output toggles on every counted data transition and feeds the transmit and receive shifters. When the master enable falls, all activity stops.

Top module: `pin_bit_timer`

## Requirements
- R1: After reset, and in every cycle while `master_en` is low, `shift_clk`, `word_done`, `start_bit` and `stop_bit` are all 0.
- R2: On the first clock after `master_en` rises, `start_bit` goes to 1. It stays 1 for two synchronized pin transitions and falls on the second of them.
- R3: The data period lasts `cmp_val + 1` synchronized pin transitions. On the last of them, `word_done` is 1 for exactly one clock cycle. It pulses at no other time.
- R4: `shift_clk` is 0 at each enable and toggles once on every transition counted in the data period. It does not change during the start or stop periods.
- R5: After `word_done`, `stop_bit` is 1 for two pin transitions. Then `start_bit` becomes 1 and the next word begins. Both flags are never 1 together.
- R6: A falling `master_en` clears every output on the next clock. Pin transitions that arrive while `master_en` is low do not count.
- R7: The block takes `cmp_val` when a data period begins. A change to `cmp_val` during a data period takes effect only on the next word.
- R8: The count depends only on the number of pin transitions. It does not depend on how many system clocks the pin holds a level (a stretched clock).
- R9: A pin transition changes the outputs at the third rising clock edge after it is applied: two synchronizer stages, then one state register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| master_en | input | 1 | Enable state of the master baud timer |
| scl_inv_pin | input | 1 | Inverted clock-line input (asynchronous) |
| cmp_val | input | CNT_W | Compare value: transitions per word minus one |
| shift_clk | output | 1 | Shift clock for the transmit and receive shifters |
| word_done | output | 1 | One-cycle pulse at the end of each word's data period |
| start_bit | output | 1 | High during the start-bit period |
| stop_bit | output | 1 | High during the stop-bit period |

## Verification
The assertions check these properties on every cycle:
- Outputs are quiet while the block is disabled.
- Start and stop periods never overlap.
- `word_done` is a one-cycle pulse, and it lines up with the start of the stop period.
- `shift_clk` moves only on a counted transition.
- The counter steps down by exactly one per counted transition.

Only the bench scenarios can show the following:
- The overall lengths of each period for a sweep of compare values.
- The three-clock latency from pin to output.
- That stretched pin levels do not change the count.
- That a compare value written mid-word has no effect until the next word.

// File: rtl/pin_bit_timer_pkg.sv
package pin_bit_timer_pkg;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_START = 2'd1,
    PH_DATA  = 2'd2,
    PH_STOP  = 2'd3
  } phase_t;

  // Down-count step: reload the compare value on reaching zero.
  function automatic logic [15:0] next_count(input logic [15:0] cur,
                                             input logic [15:0] reload);
    return (cur == '0) ? reload : cur - 16'd1;
  endfunction

  // Phases that frame a word with a two-transition bit period.
  function automatic logic is_frame_bit(input phase_t ph);
    return (ph == PH_START) || (ph == PH_STOP);
  endfunction

endpackage

// File: rtl/pin_edge_sync.sv
module pin_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_async,
  output logic edge_evt
);
  logic [STAGES-1:0] chain_q;
  logic              prev_q;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain_q[0] <= 1'b0;
          else        chain_q[0] <= pin_async;
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain_q[g] <= 1'b0;
          else        chain_q[g] <= chain_q[g-1];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= chain_q[STAGES-1];

  assign edge_evt = chain_q[STAGES-1] ^ prev_q;
endmodule

// File: rtl/frame_seq.sv
module frame_seq
  import pin_bit_timer_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   en,
  input  logic   edge_evt,
  input  logic   cnt_zero,
  output phase_t phase,
  output logic   load_cnt,
  output logic   cnt_edge,
  output logic   end_word
);
  phase_t phase_q;
  logic   half_q;
  logic   frame_edge;

  assign phase      = phase_q;
  assign cnt_edge   = en && edge_evt && (phase_q == PH_DATA);
  assign end_word   = cnt_edge && cnt_zero;
  assign frame_edge = en && edge_evt && is_frame_bit(phase_q);
  assign load_cnt   = frame_edge && half_q && (phase_q == PH_START);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      half_q  <= 1'b0;
    end else if (!en) begin
      phase_q <= PH_IDLE;
      half_q  <= 1'b0;
    end else begin
      case (phase_q)
        PH_IDLE: begin
          phase_q <= PH_START;
          half_q  <= 1'b0;
        end
        PH_DATA: begin
          if (end_word) phase_q <= PH_STOP;
        end
        default: begin
          if (frame_edge) begin
            if (half_q) begin
              phase_q <= (phase_q == PH_START) ? PH_DATA : PH_START;
              half_q  <= 1'b0;
            end else begin
              half_q  <= 1'b1;
            end
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/bit_down_counter.sv
module bit_down_counter
  import pin_bit_timer_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             load,
  input  logic             dec,
  input  logic [CNT_W-1:0] load_val,
  output logic [CNT_W-1:0] count,
  output logic             at_zero
);
  localparam int PAD_W = 16 - CNT_W;

  logic [CNT_W-1:0] cnt_q;
  logic [15:0]      step;

  generate
    if (PAD_W > 0) begin : g_pad
      logic [15:0] step_full;
      assign step_full = next_count({{PAD_W{1'b0}}, cnt_q},
                                    {{PAD_W{1'b0}}, load_val});
      assign step = step_full;
    end else begin : g_nopad
      assign step = next_count(cnt_q[15:0], load_val[15:0]);
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt_q <= '0;
    else if (clr)   cnt_q <= '0;
    else if (load)  cnt_q <= load_val;
    else if (dec)   cnt_q <= step[CNT_W-1:0];
  end

  assign count   = cnt_q;
  assign at_zero = (cnt_q == '0);
endmodule

// File: rtl/pin_bit_timer.sv
module pin_bit_timer
  import pin_bit_timer_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             master_en,
  input  logic             scl_inv_pin,
  input  logic [CNT_W-1:0] cmp_val,
  output logic             shift_clk,
  output logic             word_done,
  output logic             start_bit,
  output logic             stop_bit
);
  logic             edge_evt;
  logic             load_cnt;
  logic             cnt_edge;
  logic             end_word;
  logic             cnt_zero;
  logic [CNT_W-1:0] count;
  phase_t           phase;
  logic             sclk_q;
  logic             done_q;

  pin_edge_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .pin_async (scl_inv_pin),
    .edge_evt  (edge_evt)
  );

  frame_seq i_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (master_en),
    .edge_evt (edge_evt),
    .cnt_zero (cnt_zero),
    .phase    (phase),
    .load_cnt (load_cnt),
    .cnt_edge (cnt_edge),
    .end_word (end_word)
  );

  bit_down_counter #(.CNT_W(CNT_W)) i_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (!master_en),
    .load     (load_cnt),
    .dec      (cnt_edge),
    .load_val (cmp_val),
    .count    (count),
    .at_zero  (cnt_zero)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q <= 1'b0;
      done_q <= 1'b0;
    end else if (!master_en) begin
      sclk_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      if (cnt_edge) sclk_q <= ~sclk_q;
      done_q <= end_word;
    end
  end

  assign shift_clk = sclk_q;
  assign word_done = done_q;
  assign start_bit = (phase == PH_START);
  assign stop_bit  = (phase == PH_STOP);
endmodule

// File: rtl/pin_bit_timer_chk.sv
module pin_bit_timer_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             master_en,
  input logic             shift_clk,
  input logic             word_done,
  input logic             start_bit,
  input logic             stop_bit,
  input logic             cnt_edge,
  input logic [CNT_W-1:0] count
);
  AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !master_en |=> (!shift_clk && !word_done && !start_bit && !stop_bit)); // R6
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    word_done |=> !word_done); // R3
  AST_DONE_OPENS_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    word_done |-> stop_bit); // R5
  AST_FRAME_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(start_bit && stop_bit)); // R5
  AST_SCLK_ON_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(shift_clk) |-> ($past(cnt_edge) || !$past(master_en))); // R4
  AST_STEP_BY_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(cnt_edge) && ($past(count) != '0)) |-> (count == $past(count) - 1'b1)); // R3
endmodule

bind pin_bit_timer pin_bit_timer_chk #(.CNT_W(CNT_W)) i_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .master_en (master_en),
  .shift_clk (shift_clk),
  .word_done (word_done),
  .start_bit (start_bit),
  .stop_bit  (stop_bit),
  .cnt_edge  (cnt_edge),
  .count     (count)
);

// File: tb/test_pin_bit_timer.sv
module test_pin_bit_timer;
  localparam int CNT_W = 16;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             master_en = 1'b0;
  logic             scl_inv_pin = 1'b0;
  logic [CNT_W-1:0] cmp_val = '0;
  logic             shift_clk, word_done, start_bit, stop_bit;

  int n_run = 0;
  int n_fail = 0;
  int done_cnt = 0;

  always #2.5 clk = ~clk;

  pin_bit_timer #(.CNT_W(CNT_W), .SYNC_STAGES(2)) i_pin_bit_timer (
    .clk(clk), .rst_n(rst_n), .master_en(master_en), .scl_inv_pin(scl_inv_pin),
    .cmp_val(cmp_val), .shift_clk(shift_clk), .word_done(word_done),
    .start_bit(start_bit), .stop_bit(stop_bit)
  );

  always @(negedge clk) if (word_done) done_cnt++;

  task automatic chk(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic pin_edge(input int hold);
    scl_inv_pin = ~scl_inv_pin;
    repeat (hold) @(negedge clk);
  endtask

  task automatic enable_on();
    master_en = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic disable_off();
    master_en = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    int cmps[6] = '{0, 1, 2, 5, 9, 15};
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 shift_clk", shift_clk, 0);
    chk("R1 word_done", word_done, 0);
    chk("R1 start_bit", start_bit, 0);
    chk("R1 stop_bit", stop_bit, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1 start_bit idle", start_bit, 0);

    // Sweep of compare values; two words each, stretched holds (R8)
    foreach (cmps[k]) begin
      int exp_sc = 0;
      cmp_val = CNT_W'(cmps[k]);
      done_cnt = 0;
      enable_on();
      chk("R2 start after enable", start_bit, 1);
      chk("R4 shift_clk zero at enable", shift_clk, exp_sc);
      for (int w = 0; w < 2; w++) begin
        pin_edge(4);
        chk("R2 start held after one edge", start_bit, 1);
        pin_edge(5);
        chk("R2 start ends", start_bit, 0);
        chk("R5 no stop in data", stop_bit, 0);
        chk("R4 shift_clk stable in start", shift_clk, exp_sc);
        for (int i = 0; i <= cmps[k]; i++) begin
          pin_edge(4 + (i % 3) * 9);   // R8 stretched levels
          exp_sc ^= 1;
          chk("R4 shift_clk toggle", shift_clk, exp_sc);
          chk("R3 word_done count", done_cnt, (i == cmps[k]) ? w + 1 : w);
        end
        chk("R5 stop after word", stop_bit, 1);
        pin_edge(4);
        chk("R5 stop held", stop_bit, 1);
        chk("R4 shift_clk stable in stop", shift_clk, exp_sc);
        pin_edge(6);
        chk("R5 next start", start_bit, 1);
        chk("R5 stop ends", stop_bit, 0);
      end
      disable_off();
      chk("R6 shift_clk cleared", shift_clk, 0);
      chk("R6 start cleared", start_bit, 0);
      chk("R6 stop cleared", stop_bit, 0);
      for (int j = 0; j < 3; j++) pin_edge(4);
      chk("R6 edges ignored word_done", done_cnt, 2);
      chk("R6 edges ignored shift_clk", shift_clk, 0);
      chk("R1 word_done low while disabled", word_done, 0);
    end

    // R7 and R9: compare change mid-word, pin-to-output latency
    cmp_val = 16'd3;
    done_cnt = 0;
    enable_on();
    pin_edge(4);
    pin_edge(4);
    chk("R7 in data", start_bit, 0);
    scl_inv_pin = ~scl_inv_pin;
    repeat (2) @(negedge clk);
    chk("R9 no change after two clocks", shift_clk, 0);
    @(negedge clk);
    chk("R9 change at third clock", shift_clk, 1);
    repeat (2) @(negedge clk);
    cmp_val = 16'd7;
    for (int i = 0; i < 3; i++) pin_edge(4);
    chk("R7 current word keeps old compare", done_cnt, 1);
    pin_edge(4); pin_edge(4);   // stop
    pin_edge(4); pin_edge(4);   // start
    for (int i = 0; i < 7; i++) pin_edge(4);
    chk("R7 new compare not early", done_cnt, 1);
    pin_edge(4);
    chk("R7 new compare used", done_cnt, 2);
    disable_off();

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule